// File: doc/BRIEF.md
# Segmented Scan Shift Controller

The block holds several parallel scan chains of equal length. Each chain is cut into a fixed number of segments of equal length. During a shift sequence only one segment position is clocked at a time, and the other segments keep their contents. This lowers the switching activity compared with a full-chain shift. Segment number k of every chain is driven by the same clock enable, so the same segment index moves in all chains together. Bypass multiplexers join scan-in straight to the input of the active segment, and they route the tail of the active segment straight to scan-out, so the chain keeps a single connected serial path.

A start strobe, given while scan-enable is high, begins a sweep. The sweep first visits segment 0, which sits at the scan-out end, and moves one segment at a time towards the scan-in end. It stays on each segment for exactly one segment length of cycles. With this order the serial streams at scan-in and scan-out are the same as those of a plain unsegmented chain. When scan-enable is low the block is in capture or functional mode. In that mode every segment is enabled and every flip-flop loads its functional input. The functional outputs come straight from the flip-flops, so segmentation adds no delay to the functional path.

Top module: `seg_scan_ctrl`

## Requirements
- R1: After reset, with scan-enable high and no start, all segment enables are 0 and done is 0.
- R2: While scan-enable is low, every bit of seg_en is 1. At each clock edge every scan flip-flop loads its bit of func_d. The bit for chain c, segment k, position i (where i=0 is the segment's scan-in end) is index c*NSEG*SEGLEN + k*SEGLEN + i of func_d and of func_q.
- R3: While scan-enable is high, at most one bit of seg_en is 1 in any cycle.
- R4: A sweep starts in the cycle after start is seen while idle. It enables segment 0 for SEGLEN cycles, then segment 1, and so on up to segment NSEG-1. A bit k of seg_en set to 1 means segment k shifts.
- R5: During a sweep, scan_out[c] in each shift cycle equals the bit that a plain chain of NSEG*SEGLEN flip-flops would present. That plain chain has segment NSEG-1 at its scan-in end and segment 0 at its scan-out end. scan_in[c] is taken in that same cycle.
- R6: Segments that are not enabled hold their contents. After a full sweep, func_q holds exactly the pattern that was shifted in.
- R7: done is 1 for exactly one cycle, in the cycle after the last shift cycle of segment NSEG-1. After that, seg_en is all zeros.
- R8: A start pulse that arrives during a sweep has no effect on the order, the timing or the data of that sweep.
- R9: If scan-enable goes low during a sweep, the sweep is abandoned. When scan-enable returns high, seg_en is all zeros and done stays 0 until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | High: shift mode; low: capture / functional mode |
| start | input | 1 | Starts a sweep of all segments while idle |
| scan_in | input | NCHAIN | Serial input, one per chain |
| scan_out | output | NCHAIN | Serial output, one per chain |
| func_d | input | NCHAIN*NSEG*SEGLEN | Functional capture data |
| func_q | output | NCHAIN*NSEG*SEGLEN | Scan flip-flop contents |
| seg_en | output | NSEG | Clock enable per segment index |
| done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The hardest case to reach is a segment that must hold a value while data passes around it through the bypass path. This only shows up if the bits that were shifted in earlier stay intact through the later segments' shifts. The bench therefore first captures a known pattern, then sweeps a different pattern through the chain. It compares every scan-out bit with a plain-chain model and then reads the fully loaded pattern back on func_q. It also drops scan-enable part way through a sweep and pulses start during a sweep, so the abandon path and the ignored-start path are both exercised.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  typedef enum logic {SQ_IDLE = 1'b0, SQ_SHIFT = 1'b1} sweep_state_t;
endpackage

// File: rtl/seg_scan_seq.sv
module seg_scan_seq
  import seg_scan_pkg::*;
#(
  parameter int NSEG   = 4,
  parameter int SEGLEN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_en,
  input  logic            start,
  output logic [NSEG-1:0] seg_act,
  output logic            done
);
  localparam int IW = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int CW = (SEGLEN > 1) ? $clog2(SEGLEN) : 1;

  sweep_state_t state;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      idx   <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!scan_en) begin
        state <= SQ_IDLE;
        idx   <= '0;
        cnt   <= '0;
      end else if (state == SQ_IDLE) begin
        if (start) begin
          state <= SQ_SHIFT;
          idx   <= '0;
          cnt   <= '0;
        end
      end else if (cnt == CW'(SEGLEN - 1)) begin
        cnt <= '0;
        if (idx == IW'(NSEG - 1)) begin
          state <= SQ_IDLE;
          idx   <= '0;
          done  <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    seg_act = '0;
    if (state == SQ_SHIFT) seg_act[idx] = 1'b1;
  end
endmodule

// File: rtl/seg_scan_segment.sv
module seg_scan_segment #(
  parameter int SEGLEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              shift,
  input  logic              sin,
  input  logic [SEGLEN-1:0] cap_d,
  output logic [SEGLEN-1:0] q,
  output logic              tail
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (en) q <= shift ? {q[SEGLEN-2:0], sin} : cap_d;
  end

  assign tail = q[SEGLEN-1];
endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl #(
  parameter int NCHAIN = 2,
  parameter int NSEG   = 4,
  parameter int SEGLEN = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           scan_en,
  input  logic                           start,
  input  logic [NCHAIN-1:0]              scan_in,
  output logic [NCHAIN-1:0]              scan_out,
  input  logic [NCHAIN*NSEG*SEGLEN-1:0]  func_d,
  output logic [NCHAIN*NSEG*SEGLEN-1:0]  func_q,
  output logic [NSEG-1:0]                seg_en,
  output logic                           done
);
  localparam int CLEN = NSEG * SEGLEN;

  logic [NSEG-1:0] seg_act;
  logic [NSEG-1:0] byp;

  seg_scan_seq #(.NSEG(NSEG), .SEGLEN(SEGLEN)) i_seq (
    .clk(clk), .rst(rst), .scan_en(scan_en), .start(start),
    .seg_act(seg_act), .done(done)
  );

  assign seg_en = scan_en ? seg_act : '1;
  assign byp    = ~seg_act;

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    logic [NSEG-1:0] tl;
    logic [NSEG-1:0] si;

    assign si[NSEG-1] = scan_in[c];
    for (genvar k = 0; k < NSEG - 1; k++) begin : g_byp
      assign si[k] = byp[k+1] ? si[k+1] : tl[k+1];
    end
    assign scan_out[c] = byp[0] ? si[0] : tl[0];

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
      seg_scan_segment #(.SEGLEN(SEGLEN)) i_seg (
        .clk(clk), .rst(rst), .en(seg_en[k]), .shift(scan_en),
        .sin(si[k]),
        .cap_d(func_d[c*CLEN + k*SEGLEN +: SEGLEN]),
        .q(func_q[c*CLEN + k*SEGLEN +: SEGLEN]),
        .tail(tl[k])
      );
    end
  end
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
  parameter int NSEG = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            scan_en,
  input logic            start,
  input logic [NSEG-1:0] seg_en,
  input logic            done
);
  a_r2_all_enabled: assert property (@(posedge clk) disable iff (rst)
    !scan_en |-> (&seg_en));

  a_r3_one_segment: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> $onehot0(seg_en));

  a_r4_forward_order: assert property (@(posedge clk) disable iff (rst)
    (scan_en && $past(scan_en) && seg_en != '0 && $past(seg_en) != '0)
      |-> (seg_en == $past(seg_en) || seg_en == ($past(seg_en) << 1)));

  a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(seg_en[NSEG-1]) && $past(scan_en)));

  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    (done && scan_en) |-> (seg_en == '0));

  a_r9_abandon: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> !done);
endmodule

bind seg_scan_ctrl seg_scan_chk #(.NSEG(NSEG)) i_chk (
  .clk(clk), .rst(rst), .scan_en(scan_en), .start(start),
  .seg_en(seg_en), .done(done)
);

// File: tb/test_seg_scan_ctrl.sv
module test_seg_scan_ctrl;
  localparam int NCHAIN = 2;
  localparam int NSEG   = 4;
  localparam int SEGLEN = 4;
  localparam int CLEN   = NSEG * SEGLEN;
  localparam int W      = NCHAIN * CLEN;

  logic              clk = 1'b0;
  logic              rst;
  logic              scan_en;
  logic              start;
  logic [NCHAIN-1:0] scan_in;
  logic [NCHAIN-1:0] scan_out;
  logic [W-1:0]      func_d;
  logic [W-1:0]      func_q;
  logic [NSEG-1:0]   seg_en;
  logic              done;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] refm;

  always #10 clk = ~clk;

  seg_scan_ctrl #(.NCHAIN(NCHAIN), .NSEG(NSEG), .SEGLEN(SEGLEN)) i_seg_scan_ctrl (
    .clk(clk), .rst(rst), .scan_en(scan_en), .start(start),
    .scan_in(scan_in), .scan_out(scan_out), .func_d(func_d),
    .func_q(func_q), .seg_en(seg_en), .done(done)
  );

  function automatic int pidx(int c, int p);
    return c*CLEN + (NSEG - 1 - p/SEGLEN)*SEGLEN + (p % SEGLEN);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ref_shift(logic [NCHAIN-1:0] din);
    for (int c = 0; c < NCHAIN; c++) begin
      for (int p = CLEN - 1; p > 0; p--) refm[pidx(c, p)] = refm[pidx(c, p-1)];
      refm[pidx(c, 0)] = din[c];
    end
  endtask

  // R1
  task automatic t_reset();
    rst = 1'b1; scan_en = 1'b1; start = 1'b0; scan_in = '0; func_d = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    refm = '0;
    @(negedge clk);
    chk("R1 seg_en", W'(seg_en), '0);
    chk("R1 done", W'(done), '0);
    chk("R1 func_q", func_q, '0);
  endtask

  // R2: capture with all segments enabled
  task automatic t_capture(logic [W-1:0] val);
    scan_en = 1'b0; func_d = val;
    #5 chk("R2 all enabled", W'(seg_en), W'({NSEG{1'b1}}));
    @(negedge clk);
    chk("R2 captured", func_q, val);
    refm = val;
    scan_en = 1'b1;
    #5 chk("R2 idle after capture", W'(seg_en), '0);
    @(negedge clk);
  endtask

  // R3 R4 R5 R6 R7 R8: full sweep, optional stray start at cycle 5
  task automatic t_sweep(int seed, bit stray);
    logic [15:0] lf = 16'(seed) | 16'h1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < CLEN; j++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      scan_in = lf[NCHAIN-1:0];
      start = (stray && j == 5);
      #5;
      chk(stray ? "R8 R4 seg_en" : "R3 R4 seg_en", W'(seg_en), W'(NSEG'(1) << (j / SEGLEN)));
      for (int c = 0; c < NCHAIN; c++)
        chk(stray ? "R8 R5 scan_out" : "R5 scan_out", W'(scan_out[c]), W'(refm[pidx(c, CLEN-1)]));
      @(negedge clk);
      ref_shift(lf[NCHAIN-1:0]);
    end
    start = 1'b0;
    chk("R7 done pulse", W'(done), 1);
    chk("R7 idle after sweep", W'(seg_en), '0);
    chk("R6 loaded pattern", func_q, refm);
    @(negedge clk);
    chk("R7 done single", W'(done), '0);
    chk("R6 pattern held", func_q, refm);
  endtask

  // R9: abandon mid sweep
  task automatic t_abort();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < 3; j++) begin
      scan_in = NCHAIN'(j + 1);
      @(negedge clk);
      ref_shift(NCHAIN'(j + 1));
    end
    scan_en = 1'b0; func_d = {W/4{4'h9}};
    #5 chk("R9 R2 all enabled on abort", W'(seg_en), W'({NSEG{1'b1}}));
    @(negedge clk);
    refm = func_d;
    scan_en = 1'b1;
    for (int j = 0; j < CLEN + 2; j++) begin
      #5;
      chk("R9 idle seg_en", W'(seg_en), '0);
      chk("R9 no done", W'(done), '0);
      @(negedge clk);
    end
    chk("R9 contents kept", func_q, refm);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_capture({W/16{16'hC35A}});
    t_sweep(37, 1'b0);
    t_capture({W/8{8'h6B}});
    t_sweep(911, 1'b1);
    t_abort();
    t_sweep(4242, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule